// File: doc/BRIEF.md
# Program Counter and Return Stack

This unit holds the 13-bit program counter of a small 8-bit controller core, along with the hidden return stack. In each cycle the core asserts at most one sequencing request, and the unit picks the next PC from that request. The requests are:

- advance by one;
- a direct jump or a call to an 11-bit target taken from the opcode;
- a write of the PC low byte from the ALU;
- a return;
- an interrupt.

A 5-bit upper-address latch, written by the core, supplies the high PC bits. A low-byte write takes all five latch bits. A jump or call takes only the top two.

The return stack has eight entries and is circular. It never reports overflow or underflow: a ninth push overwrites the oldest entry, and extra pops return whatever entry the pointer lands on. The fetch address sent to program memory is the PC reduced modulo the implemented memory size. On a 1K-word part, for example, 0020h, 0420h and 0820h all fetch the same word.

Top module: `pc_unit`

## Requirements
- R1: After reset the PC and the fetch address are 0000h and the upper-address latch is 0.
- R2: An advance request sets the PC to PC+1 in the next cycle, and 1FFFh rolls over to 0000h.
- R3: A low-byte write sets the PC to {latch[4:0], data[7:0]}.
- R4: A jump sets the PC to {latch[4:3], target[10:0]}.
- R5: A call loads the same target as a jump and pushes the address after the call (PC+1).
- R6: A return loads the PC from the most recently pushed stack entry. Push and pop leave the upper-address latch unchanged.
- R7: An interrupt sets the PC to 0004h and pushes the current PC, which is the instruction not yet executed.
- R8: The stack holds 8 entries and its pointer wraps modulo 8 in both directions. A ninth push overwrites the first entry. Popping more times than pushed returns stale entries, and no flag is raised.
- R9: The fetch address equals the PC modulo MEM_WORDS (default 1024 words).
- R10: When several requests arrive together, the priority is interrupt > return > call > jump > low-byte write > advance. With no request, the PC holds.
- R11: A latch write takes effect from the next cycle. A PC request in the same cycle uses the old latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance PC by one |
| jump_en | input | 1 | Jump to opcode target |
| call_en | input | 1 | Call opcode target, pushing return address |
| target | input | 11 | Opcode target address |
| lo_wr | input | 1 | Write PC low byte |
| lo_data | input | 8 | Low byte value from the ALU |
| ret_en | input | 1 | Pop the stack into the PC |
| irq_en | input | 1 | Vector to the interrupt address |
| hi_wr | input | 1 | Write the upper-address latch |
| hi_data | input | 5 | Latch value |
| pc | output | 13 | Full program counter |
| fetch_addr | output | 13 | PC wrapped to implemented memory |

## Verification
Two functions can coincide in one cycle: a write to the upper-address latch and a PC load that reads that latch. The bench provokes this by asserting a latch write together with a low-byte write. It expects the PC to carry the old latch bits, then issues a second low-byte write alone and expects the new bits. Competing sequencing requests are also asserted together, and only the highest-priority one must take effect, including its stack side effect.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int PC_W      = 13,
  parameter int LO_W      = 8,
  parameter int TGT_W     = 11,
  parameter int STK_DEPTH = 8,
  parameter int MEM_WORDS = 1024,
  parameter int IRQ_VEC   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 jump_en,
  input  logic                 call_en,
  input  logic [TGT_W-1:0]     target,
  input  logic                 lo_wr,
  input  logic [LO_W-1:0]      lo_data,
  input  logic                 ret_en,
  input  logic                 irq_en,
  input  logic                 hi_wr,
  input  logic [PC_W-LO_W-1:0] hi_data,
  output logic [PC_W-1:0]      pc,
  output logic [PC_W-1:0]      fetch_addr
);
  localparam int HI_W  = PC_W - LO_W;
  localparam int PAGE_W = PC_W - TGT_W;
  localparam int SP_W  = $clog2(STK_DEPTH);
  localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);
  localparam logic [PC_W-1:0] VEC  = PC_W'(IRQ_VEC);

  logic [HI_W-1:0] hi_q;
  logic [PC_W-1:0] stk [STK_DEPTH];
  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] pc_nxt;

  wire [PC_W-1:0] pc_inc   = pc + 1'b1;
  wire [PC_W-1:0] jmp_tgt  = {hi_q[HI_W-1 -: PAGE_W], target};
  wire [PC_W-1:0] lo_tgt   = {hi_q, lo_data};
  wire [SP_W-1:0] sp_dn    = sp - 1'b1;
  wire            do_pop   = ret_en & ~irq_en;
  wire            do_push  = irq_en | (call_en & ~ret_en);
  wire [PC_W-1:0] push_val = irq_en ? pc : pc_inc;

  always_comb begin
    if (irq_en)                 pc_nxt = VEC;
    else if (ret_en)            pc_nxt = stk[sp_dn];
    else if (call_en | jump_en) pc_nxt = jmp_tgt;
    else if (lo_wr)             pc_nxt = lo_tgt;
    else if (step_en)           pc_nxt = pc_inc;
    else                        pc_nxt = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      hi_q <= '0;
      sp   <= '0;
    end else begin
      pc <= pc_nxt;
      if (hi_wr) hi_q <= hi_data;
      if (do_pop)       sp <= sp_dn;
      else if (do_push) sp <= sp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
    end else if (do_push & ~do_pop) begin
      stk[sp] <= push_val;
    end
  end

  assign fetch_addr = pc & MASK;
endmodule

module pc_unit_chk #(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int TGT_W   = 11,
  parameter int IRQ_VEC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             jump_en,
  input logic             call_en,
  input logic [TGT_W-1:0] target,
  input logic             lo_wr,
  input logic [LO_W-1:0]  lo_data,
  input logic             ret_en,
  input logic             irq_en,
  input logic [PC_W-1:0]  pc
);
  wire none_hi = ~irq_en & ~ret_en & ~call_en & ~jump_en;

  assert_irq_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> pc == PC_W'(IRQ_VEC));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (none_hi & ~lo_wr & step_en) |=> pc == $past(pc) + 1'b1);

  assert_jump_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (~irq_en & ~ret_en & (jump_en | call_en)) |=> pc[TGT_W-1:0] == $past(target));

  assert_lo_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (none_hi & lo_wr) |=> pc[LO_W-1:0] == $past(lo_data));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (none_hi & ~lo_wr & ~step_en) |=> $stable(pc));
endmodule

bind pc_unit pc_unit_chk #(.PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en), .call_en(call_en),
  .target(target), .lo_wr(lo_wr), .lo_data(lo_data), .ret_en(ret_en), .irq_en(irq_en),
  .pc(pc)
);

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
  localparam int CLK_P = 10;
  localparam int F_STEP = 1, F_LO = 2, F_JMP = 4, F_CALL = 8, F_RET = 16, F_IRQ = 32, F_HI = 64;

  logic clk = 0, rst_n = 0;
  logic step_en = 0, jump_en = 0, call_en = 0, lo_wr = 0, ret_en = 0, irq_en = 0, hi_wr = 0;
  logic [10:0] target = '0;
  logic [7:0]  lo_data = '0;
  logic [4:0]  hi_data = '0;
  logic [12:0] pc, fetch_addr;

  int total = 0, bad = 0;
  logic [12:0] m_pc = 0;
  logic [4:0]  m_hi = 0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = 0;
  logic [12:0] q_pc [$];
  string       q_tag [$];

  always #(CLK_P/2) clk = ~clk;

  pc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en), .call_en(call_en),
    .target(target), .lo_wr(lo_wr), .lo_data(lo_data), .ret_en(ret_en), .irq_en(irq_en),
    .hi_wr(hi_wr), .hi_data(hi_data), .pc(pc), .fetch_addr(fetch_addr)
  );

  task automatic check(input string tag, input logic [12:0] exp_pc);
    logic [12:0] exp_fa;
    exp_fa = exp_pc & 13'h03FF;
    total++;
    if (pc !== exp_pc || fetch_addr !== exp_fa) begin
      bad++;
      $display("FAIL %s pc=%h exp=%h fetch=%h exp=%h", tag, pc, exp_pc, fetch_addr, exp_fa);
    end
  endtask

  always @(negedge clk) begin
    while (q_pc.size() > 0) check(q_tag.pop_front(), q_pc.pop_front());
  end

  task automatic op(input int f, input logic [10:0] tgt, input logic [7:0] lo,
                    input logic [4:0] hi, input string tag);
    logic [12:0] nxt;
    @(negedge clk);
    step_en = (f & F_STEP) != 0; lo_wr = (f & F_LO) != 0; jump_en = (f & F_JMP) != 0;
    call_en = (f & F_CALL) != 0; ret_en = (f & F_RET) != 0; irq_en = (f & F_IRQ) != 0;
    hi_wr = (f & F_HI) != 0; target = tgt; lo_data = lo; hi_data = hi;
    if (irq_en) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 1; nxt = 13'h0004;
    end else if (ret_en) begin
      m_sp = m_sp - 1; nxt = m_stk[m_sp];
    end else if (call_en) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 1; nxt = {m_hi[4:3], tgt};
    end else if (jump_en) nxt = {m_hi[4:3], tgt};
    else if (lo_wr)       nxt = {m_hi, lo};
    else if (step_en)     nxt = m_pc + 13'd1;
    else                  nxt = m_pc;
    m_pc = nxt;
    if (hi_wr) m_hi = hi;
    @(posedge clk);
    #1;
    {step_en, lo_wr, jump_en, call_en, ret_en, irq_en, hi_wr} = '0;
    q_pc.push_back(m_pc);
    q_tag.push_back(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 13'h0000);
    rst_n = 1;
    op(F_HI, 0, 0, 5'h1B, "R11 latch write alone holds pc");
    op(0, 0, 0, 0, "R10 idle hold");
    op(F_STEP, 0, 0, 0, "R2 step");
    op(F_STEP, 0, 0, 0, "R2 step");
    op(F_LO, 0, 8'h5A, 0, "R3 R9 low byte write");
    op(F_JMP, 11'h123, 0, 0, "R4 jump");
    op(F_CALL, 11'h456, 0, 0, "R5 call");
    op(F_IRQ, 0, 0, 0, "R7 interrupt vector");
    op(F_STEP, 0, 0, 0, "R2 step in handler");
    op(F_RET, 0, 0, 0, "R6 R7 return from interrupt");
    op(F_RET, 0, 0, 0, "R6 R5 return from call");
    op(F_LO, 0, 8'h00, 0, "R6 latch kept across push and pop");
    op(F_HI | F_LO, 0, 8'h11, 5'h02, "R11 same-cycle latch uses old value");
    op(F_LO, 0, 8'h22, 0, "R11 new latch value next cycle");
    op(F_IRQ | F_RET | F_CALL, 11'h7AA, 0, 0, "R10 irq wins");
    op(F_RET | F_CALL, 11'h0AA, 0, 0, "R10 ret beats call");
    op(F_JMP | F_LO | F_STEP, 11'h0F0, 8'h77, 0, "R10 jump beats low write");
    op(F_LO | F_STEP, 0, 8'h77, 0, "R10 low write beats step");
    op(F_HI, 0, 0, 5'h1F, "R11 latch to top page");
    op(F_LO, 0, 8'hFF, 0, "R9 pc at 1FFF");
    op(F_STEP, 0, 0, 0, "R2 rollover to zero");
    for (int k = 0; k < 9; k++) op(F_CALL, 11'(16 * k + 3), 0, 0, "R8 push sequence");
    for (int k = 0; k < 10; k++) op(F_RET, 0, 0, 0, "R8 circular pop");
    op(F_JMP, 11'h420, 0, 5'h00, "R9 fetch wraps");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule